// File: doc/BRIEF.md
# Dual-Bank Serial Shift and Latch Core for a Dot-Matrix LCD Driver

This block is the digital core of a 40-channel dot-matrix LCD driver. The channels are split into two banks of 20. Each bank has its own serial shift register, parallel latch and direction input. Serial data enters at one end pin of a bank and moves one stage per shift event. The bit in the last stage is driven out of the opposite end pin, so that several devices can be chained. A latch event copies the whole shift register into the bank's latch.

Two strobes drive the banks. A mode input decides how they are used. When the mode is low, both banks work as column drivers. When it is high, bank 1 stays a column driver and bank 2 becomes a row driver. The two strobes trade their shift and latch roles in row mode. Each strobe is synchronised to the system clock, and only its falling edge has an effect.

For each channel the block gives a 3-bit code that selects one of six bias levels. The code depends on the latched bit, the alternation input and the mode of the bank. The analog switches that act on these codes are outside the block.

Top module: `lcd_shift_latch_drv`

## Requirements
- R1: A synchronous active-high reset clears every shift stage and every latch bit to 0. The end-pin outputs are then 0, and each channel code follows R9 with a latched bit of 0.
- R2: Bank 1 holds channels 1–20, which are bits 0–19 of `lat_bits` and codes 0–19 of `lvl_codes`. Bank 2 holds channels 21–40, which are bits 20–39 and codes 20–39. Code k sits at bits [3k+2:3k] of `lvl_codes`.
- R3: When `row_mode` is 0, both banks are column banks. When it is 1, bank 2 is a row bank and bank 1 stays a column bank.
- R4: In a column bank, a falling edge of `strobe_b` shifts the register by one stage, and a falling edge of `strobe_a` copies the register into the latch.
- R5: In a row bank the strobes trade roles: a falling edge of `strobe_a` shifts, and a falling edge of `strobe_b` latches.
- R6: When a bank's `dir` bit is 0, a shift loads that bank's `end_l_in` into channel stage 0. Each stage moves up one channel, and `end_r_out` carries the highest stage.
- R7: When a bank's `dir` bit is 1, a shift loads `end_r_in` into the highest stage. Each stage moves down one channel, and `end_l_out` carries stage 0.
- R8: Each end pin has its own output enable. `end_r_oe` equals 1 when `dir` is 0, and `end_l_oe` equals 1 when `dir` is 1. An end pin that is not enabled drives 0.
- R9: In a column bank, the code for (latched bit, `alt_m`) is: (1,1)→1, (1,0)→2, (0,1)→3, (0,0)→4.
- R10: In a row bank, the code for (latched bit, `alt_m`) is: (1,1)→2, (1,0)→1, (0,1)→6, (0,0)→5.
- R11: `alt_m` changes only the codes. It never changes the shift or latch contents.
- R12: Shift and latch take place on the falling edge of a strobe, within a few system clocks. A rising edge changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe_a | input | 1 | Latch strobe in column mode, shift strobe in row mode (asynchronous) |
| strobe_b | input | 1 | Shift strobe in column mode, latch strobe in row mode (asynchronous) |
| row_mode | input | 1 | 1 makes bank 2 a row bank |
| alt_m | input | 1 | Drive alternation input |
| dir | input | 2 | Shift direction, one bit per bank |
| end_l_in | input | 2 | Left end pin input, one bit per bank |
| end_r_in | input | 2 | Right end pin input, one bit per bank |
| end_l_out | output | 2 | Left end pin output value |
| end_l_oe | output | 2 | Left end pin output enable |
| end_r_out | output | 2 | Right end pin output value |
| end_r_oe | output | 2 | Right end pin output enable |
| lat_bits | output | 40 | Latched data for each channel |
| lvl_codes | output | 120 | 3-bit level code for each channel |

## Verification
The assertions assume that the end-pin data, `dir` and `row_mode` stay stable while a synchronised strobe edge is in flight, because only the strobes pass through synchronisers. The bench changes data and mode only on falling clock edges, while both strobes are high. It then holds every strobe level for six clocks, which is longer than the synchroniser and edge-detect delay. This keeps every event separate and sampled from stable inputs.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;

  localparam lvl_t LVL_1 = 3'd1;
  localparam lvl_t LVL_2 = 3'd2;
  localparam lvl_t LVL_3 = 3'd3;
  localparam lvl_t LVL_4 = 3'd4;
  localparam lvl_t LVL_5 = 3'd5;
  localparam lvl_t LVL_6 = 3'd6;

  // Column bank: the data bit picks the pair (1/2 or 3/4); alt picks inside the pair.
  function automatic lvl_t col_level(input logic bit_d, input logic alt);
    if (bit_d) return alt ? LVL_1 : LVL_2;
    else       return alt ? LVL_3 : LVL_4;
  endfunction

  // Row bank: select pair 1/2 or 5/6 with the alternation sense reversed.
  function automatic lvl_t row_level(input logic bit_d, input logic alt);
    if (bit_d) return alt ? LVL_2 : LVL_1;
    else       return alt ? LVL_6 : LVL_5;
  endfunction

  function automatic lvl_t pick_level(input logic is_row, input logic bit_d,
                                      input logic alt);
    return is_row ? row_level(bit_d, alt) : col_level(bit_d, alt);
  endfunction
endpackage

// File: rtl/strobe_fall_det.sv
module strobe_fall_det #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q[0] <= raw;
      prev_q    <= sync_q[STAGES-1];
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign fall = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/bank_shift_latch.sv
module bank_shift_latch #(
  parameter int N = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_ev,
  input  logic         latch_ev,
  input  logic         dir,
  input  logic         l_in,
  input  logic         r_in,
  output logic         l_out,
  output logic         l_oe,
  output logic         r_out,
  output logic         r_oe,
  output logic [N-1:0] lat_q
);
  logic [N-1:0] sr_q;
  logic [N-1:0] sr_up;
  logic [N-1:0] sr_dn;

  assign sr_up = {sr_q[N-2:0], l_in};
  assign sr_dn = {r_in, sr_q[N-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= '0;
      lat_q <= '0;
    end else begin
      if (latch_ev) lat_q <= sr_q;
      if (shift_ev) sr_q  <= dir ? sr_dn : sr_up;
    end
  end

  assign r_oe  = ~dir;
  assign l_oe  = dir;
  assign r_out = ~dir & sr_q[N-1];
  assign l_out = dir & sr_q[0];

  // R6
  lft_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_ev && !dir) |=> sr_q[0] == $past(l_in));
  // R7
  rgt_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_ev && dir) |=> sr_q[N-1] == $past(r_in));
  // R6
  cascade_step_chk: assert property (@(posedge clk) disable iff (rst)
    (shift_ev && !dir && !$past(rst)) |=> (dir || r_out == $past(sr_q[N-2])));
  // R4
  latch_copy_chk: assert property (@(posedge clk) disable iff (rst)
    latch_ev |=> lat_q == $past(sr_q));
  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!shift_ev && !latch_ev) |=> ($stable(sr_q) && $stable(lat_q)));
endmodule

// File: rtl/bank_level_map.sv
module bank_level_map
  import lcd_drv_pkg::*;
#(
  parameter int N = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               is_row,
  input  logic               alt,
  input  logic [N-1:0]       lat,
  output logic [N*LVL_W-1:0] codes
);
  for (genvar c = 0; c < N; c++) begin : g_ch
    lvl_t code_c;
    assign code_c = pick_level(is_row, lat[c], alt);
    assign codes[c*LVL_W +: LVL_W] = code_c;

    // R10
    row_set_chk: assert property (@(posedge clk) disable iff (rst)
      is_row |-> (code_c == LVL_1 || code_c == LVL_2 ||
                  code_c == LVL_5 || code_c == LVL_6));
    // R9
    col_set_chk: assert property (@(posedge clk) disable iff (rst)
      !is_row |-> (code_c >= LVL_1 && code_c <= LVL_4));
  end
endmodule

// File: rtl/lcd_shift_latch_drv.sv
module lcd_shift_latch_drv
  import lcd_drv_pkg::*;
#(
  parameter int CH_PER_BANK = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          strobe_a,
  input  logic                          strobe_b,
  input  logic                          row_mode,
  input  logic                          alt_m,
  input  logic [1:0]                    dir,
  input  logic [1:0]                    end_l_in,
  input  logic [1:0]                    end_r_in,
  output logic [1:0]                    end_l_out,
  output logic [1:0]                    end_l_oe,
  output logic [1:0]                    end_r_out,
  output logic [1:0]                    end_r_oe,
  output logic [2*CH_PER_BANK-1:0]      lat_bits,
  output logic [2*CH_PER_BANK*3-1:0]    lvl_codes
);
  localparam int BANKS = 2;
  localparam int BW    = CH_PER_BANK * LVL_W;

  logic       fall_a;
  logic       fall_b;
  logic [1:0] bank_row;
  logic [1:0] shift_ev;
  logic [1:0] latch_ev;

  strobe_fall_det #(.STAGES(SYNC_STAGES)) u_det_a (
    .clk(clk), .rst(rst), .raw(strobe_a), .fall(fall_a));
  strobe_fall_det #(.STAGES(SYNC_STAGES)) u_det_b (
    .clk(clk), .rst(rst), .raw(strobe_b), .fall(fall_b));

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    if (b == BANKS - 1) begin : g_row_capable
      assign bank_row[b] = row_mode;
    end else begin : g_col_only
      assign bank_row[b] = 1'b0;
    end

    assign shift_ev[b] = bank_row[b] ? fall_a : fall_b;
    assign latch_ev[b] = bank_row[b] ? fall_b : fall_a;

    logic [CH_PER_BANK-1:0] lat_b;

    bank_shift_latch #(.N(CH_PER_BANK)) u_bank (
      .clk(clk), .rst(rst),
      .shift_ev(shift_ev[b]), .latch_ev(latch_ev[b]), .dir(dir[b]),
      .l_in(end_l_in[b]), .r_in(end_r_in[b]),
      .l_out(end_l_out[b]), .l_oe(end_l_oe[b]),
      .r_out(end_r_out[b]), .r_oe(end_r_oe[b]),
      .lat_q(lat_b));

    assign lat_bits[b*CH_PER_BANK +: CH_PER_BANK] = lat_b;

    bank_level_map #(.N(CH_PER_BANK)) u_map (
      .clk(clk), .rst(rst), .is_row(bank_row[b]), .alt(alt_m),
      .lat(lat_b), .codes(lvl_codes[b*BW +: BW]));
  end

  // R11
  alt_keeps_latch_chk: assert property (@(posedge clk) disable iff (rst)
    (!fall_a && !fall_b) |=> $stable(lat_bits));
  // R3
  col_bank_keeps_roles_chk: assert property (@(posedge clk) disable iff (rst)
    fall_b |-> shift_ev[0]);
endmodule

// File: tb/lcd_shift_latch_drv_bench.sv
module lcd_shift_latch_drv_bench;
  localparam int N = 20;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         strobe_a = 1'b0, strobe_b = 1'b0;
  logic         row_mode = 1'b0, alt_m = 1'b0;
  logic [1:0]   dir = 2'b00, end_l_in = 2'b00, end_r_in = 2'b00;
  logic [1:0]   end_l_out, end_l_oe, end_r_out, end_r_oe;
  logic [39:0]  lat_bits;
  logic [119:0] lvl_codes;

  int checks = 0, errors = 0;
  logic done = 1'b0;

  logic [N-1:0] msr [2];
  logic [N-1:0] mlat[2];

  always #10 clk = ~clk;

  lcd_shift_latch_drv u_lcd_shift_latch_drv (
    .clk(clk), .rst(rst), .strobe_a(strobe_a), .strobe_b(strobe_b),
    .row_mode(row_mode), .alt_m(alt_m), .dir(dir),
    .end_l_in(end_l_in), .end_r_in(end_r_in),
    .end_l_out(end_l_out), .end_l_oe(end_l_oe),
    .end_r_out(end_r_out), .end_r_oe(end_r_oe),
    .lat_bits(lat_bits), .lvl_codes(lvl_codes));

  // {row_mode, dir[1], dir[0], bank2 pattern, bank1 pattern}
  localparam logic [42:0] VEC [6] = '{
    {1'b0, 2'b00, 20'hA5C3E, 20'h1F0D2},
    {1'b0, 2'b11, 20'h0F0F1, 20'hC3A59},
    {1'b0, 2'b01, 20'hFFFFF, 20'h00001},
    {1'b1, 2'b00, 20'h3E7A1, 20'h8B24D},
    {1'b1, 2'b10, 20'h80000, 20'h5A5A5},
    {1'b1, 2'b11, 20'h6D193, 20'hFFFFE}
  };

  function automatic logic [2:0] ref_code(input logic rowb, input logic d,
                                          input logic m);
    logic [1:0] sel = {d, m};
    case (sel)
      2'b11: return rowb ? 3'd2 : 3'd1;
      2'b10: return rowb ? 3'd1 : 3'd2;
      2'b01: return rowb ? 3'd6 : 3'd3;
      default: return rowb ? 3'd5 : 3'd4;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [119:0] act,
                     input logic [119:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic pa, input logic pb, input logic [1:0] lin,
                       input logic [1:0] rin);
    @(negedge clk);
    end_l_in = lin;
    end_r_in = rin;
    for (int b = 0; b < 2; b++) begin
      logic rowb = (b == 1) && row_mode;
      logic sh   = rowb ? pa : pb;
      logic la   = rowb ? pb : pa;
      logic [N-1:0] old = msr[b];
      if (la) mlat[b] = old;
      if (sh) msr[b] = dir[b] ? {rin[b], old[N-1:1]} : {old[N-2:0], lin[b]};
    end
    if (pa) strobe_a = 1'b0;
    if (pb) strobe_b = 1'b0;
    repeat (6) @(negedge clk);
    strobe_a = 1'b1;
    strobe_b = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [1:0] er_out, el_out;
    logic [119:0] ec;
    for (int b = 0; b < 2; b++) begin
      er_out[b] = dir[b] ? 1'b0 : msr[b][N-1];
      el_out[b] = dir[b] ? msr[b][0] : 1'b0;
    end
    chk({tag, " R2 latch"}, {80'd0, lat_bits}, {80'd0, mlat[1], mlat[0]});
    chk({tag, " R8 oe"}, {116'd0, end_l_oe, end_r_oe}, {116'd0, dir, ~dir});
    chk({tag, " R6 R7 cascade"}, {116'd0, end_l_out, end_r_out},
        {116'd0, el_out, er_out});
    for (int mv = 0; mv < 2; mv++) begin
      @(negedge clk);
      alt_m = mv[0];
      @(negedge clk);
      for (int k = 0; k < 40; k++) begin
        logic rowb = (k >= N) && row_mode;
        logic d = (k >= N) ? mlat[1][k-N] : mlat[0][k];
        ec[3*k +: 3] = ref_code(rowb, d, mv[0]);
      end
      chk({tag, row_mode ? " R10 R9 codes" : " R9 codes"}, lvl_codes, ec);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [119:0] ec0;
    logic [39:0]  keep;
    logic [1:0]   keep_out;
    for (int b = 0; b < 2; b++) begin msr[b] = '0; mlat[b] = '0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state, alt_m = 0 gives code 4 on every channel
    for (int k = 0; k < 40; k++) ec0[3*k +: 3] = 3'd4;
    chk("R1 latch zero", {80'd0, lat_bits}, 120'd0);
    chk("R1 pins zero", {116'd0, end_l_out, end_r_out}, 120'd0);
    chk("R1 codes", lvl_codes, ec0);
    // R12: rising edges of both strobes change nothing
    end_l_in = 2'b11;
    end_r_in = 2'b11;
    strobe_a = 1'b1;
    strobe_b = 1'b1;
    repeat (8) @(negedge clk);
    chk("R12 rise no latch", {80'd0, lat_bits}, 120'd0);
    chk("R12 rise no shift", {116'd0, end_l_out, end_r_out}, 120'd0);

    // Table walk: R3 R4 R5 R6 R7 R8 R9 R10
    for (int v = 0; v < 6; v++) begin
      logic [42:0] e = VEC[v];
      @(negedge clk);
      row_mode = e[42];
      dir      = e[41:40];
      for (int i = 0; i < N; i++) begin
        logic [1:0] bits = {e[20+i], e[i]};
        logic [1:0] li, ri;
        for (int b = 0; b < 2; b++) begin
          li[b] = dir[b] ? ~bits[b] : bits[b];
          ri[b] = dir[b] ? bits[b] : ~bits[b];
        end
        pulse(row_mode, 1'b1, li, ri);
      end
      pulse(1'b1, 1'b0, 2'b01, 2'b10);
      check_all(row_mode ? "vec R5" : "vec R4");
    end

    // R12: the latch follows the falling edge, before the strobe rises again
    @(negedge clk);
    row_mode = 1'b0;
    dir = 2'b00;
    for (int i = 0; i < 3; i++) pulse(1'b0, 1'b1, 2'b11, 2'b00);
    @(negedge clk);
    strobe_a = 1'b0;
    mlat[0] = msr[0];
    mlat[1] = msr[1];
    repeat (6) @(negedge clk);
    chk("R12 latch on fall", {80'd0, lat_bits}, {80'd0, mlat[1], mlat[0]});
    strobe_a = 1'b1;
    repeat (6) @(negedge clk);
    chk("R12 rise after fall", {80'd0, lat_bits}, {80'd0, mlat[1], mlat[0]});

    // R11: toggling alt_m leaves latch and shift contents alone
    keep = lat_bits;
    keep_out = end_r_out;
    for (int t = 0; t < 5; t++) begin
      @(negedge clk);
      alt_m = ~alt_m;
    end
    repeat (4) @(negedge clk);
    chk("R11 latch kept", {80'd0, lat_bits}, {80'd0, keep});
    chk("R11 shift kept", {118'd0, end_r_out}, {118'd0, keep_out});

    // R3: a column-mode shift on strobe_b reaches bank 2 with row_mode low
    pulse(1'b0, 1'b1, 2'b00, 2'b00);
    chk("R3 bank2 column shift", {118'd0, end_r_out},
        {118'd0, msr[1][N-1], msr[0][N-1]});

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule